// File: doc/BRIEF.md
# DRAM Command Timing Guard

This block stands between a DRAM command scheduler and the memory interface. Each cycle the scheduler may present up to four candidate commands at once: an auto-refresh, a precharge to one bank, a column access (read or write) to one bank, and an activate to one bank. The guard checks every candidate against the open or closed state of the banks and against the programmed timing limits. It then grants at most one of them in the same cycle and reports the command that goes out. A candidate that makes no sense for the current bank state is refused and flagged, so the scheduler can detect its own bookkeeping faults.

The timing limits come from a 64-bit configuration word. Fields that apply to one bank (activate-to-column, precharge-to-activate, the row cycle) are tracked by per-bank elapsed-cycle counters. Limits that span banks (activate-to-activate across banks, write-to-read, refresh recovery) use global counters. The row cycle depends on how the row was used. If the row saw any write while it was open, the longer write-row value applies. Both row-cycle fields are programmed one below the real count.

Top module: `dram_timing_guard`

## Requirements
- R1: After reset no command is granted, `cmd_valid_o` is 0, and every bank is closed, so a column or precharge request to any bank is flagged illegal.
- R2: A READ or WRITE to a bank issues no earlier than N cycles after that bank's ACTIVATE, where N is cfg bits 3:0 and a value of 0 acts as 1.
- R3: An ACTIVATE to a bank issues no earlier than N cycles after that bank's PRECHARGE, where N is cfg bits 19:16 and 0 acts as 1.
- R4: An ACTIVATE issues no earlier than N cycles after the most recent ACTIVATE to a different bank, where N is cfg bits 23:20 and 0 acts as 1. A repeat ACTIVATE to the same bank is not subject to this limit.
- R5: Two ACTIVATEs to the same bank are at least F+1 cycles apart. F is cfg bits 27:24 if any WRITE went to that bank since its last ACTIVATE, and cfg bits 31:28 otherwise.
- R6: A READ to any bank issues no earlier than N cycles after the most recent WRITE to any bank, where N is cfg bits 43:40 (0 means no extra gap).
- R7: After an AUTO-REFRESH, no ACTIVATE and no further AUTO-REFRESH issues for N cycles, where N is cfg bits 55:52. An AUTO-REFRESH also needs every bank closed and each bank's precharge limit (R3) elapsed.
- R8: At most one grant bit is set per cycle. Among the requests that are legal and timing-ready, the priority is refresh (grant bit 3) over precharge (bit 2) over column (bit 1) over activate (bit 0).
- R9: These requests are refused and flagged on the matching `illegal_o` bit (same bit order as the grants) and never granted: ACTIVATE to an open bank, READ, WRITE or PRECHARGE to a closed bank, and AUTO-REFRESH while any bank is open.
- R10: Configuration bits outside the seven timing fields have no effect on any grant.
- R11: The issued command code is NOP=0, ACT=1, RD=2, WR=3, PRE=4, REF=5. `cmd_bank_o` carries the target bank and is 0 for REF and NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_i | input | 64 | Timing configuration word |
| ref_req_i | input | 1 | Auto-refresh request |
| pre_req_i | input | 1 | Precharge request |
| pre_bank_i | input | BANK_W | Precharge target bank |
| col_req_i | input | 1 | Column access request |
| col_wr_i | input | 1 | Column access is a write (1) or read (0) |
| col_bank_i | input | BANK_W | Column access target bank |
| act_req_i | input | 1 | Activate request |
| act_bank_i | input | BANK_W | Activate target bank |
| grant_o | output | 4 | One-hot grant: 3 refresh, 2 precharge, 1 column, 0 activate |
| illegal_o | output | 4 | Request refused for bank state, same bit order |
| cmd_valid_o | output | 1 | A command issues this cycle |
| cmd_o | output | 3 | Issued command code |
| cmd_bank_o | output | BANK_W | Issued command bank |

## Verification
The hardest case to reach is the row-cycle choice in R5. The limit depends on history inside a row's open period, and at the ports it is usually hidden behind the precharge limit. The stimulus sets the precharge limit to 1 and the two row-cycle fields far apart. It then runs ACTIVATE, column access, PRECHARGE, ACTIVATE on one bank, once with a write and once with a read, so the row-cycle limit alone sets the reopen cycle. Refresh recovery and write-to-read are reached the same way, by shrinking every competing limit. Long random request phases under random configurations are then compared cycle by cycle against a behavioural model.

// File: rtl/dct_pkg.sv
package dct_pkg;

    localparam int CFG_W = 64;
    localparam int LIM_W = 5;
    localparam int N_CLS = 4;

    localparam int CLS_ACT = 0;
    localparam int CLS_COL = 1;
    localparam int CLS_PRE = 2;
    localparam int CLS_REF = 3;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5
    } dram_cmd_e;

    typedef struct packed {
        logic [LIM_W-1:0] rcd;
        logic [LIM_W-1:0] rp;
        logic [LIM_W-1:0] rrd;
        logic [LIM_W-1:0] rc_wr;
        logic [LIM_W-1:0] rc_rd;
        logic [LIM_W-1:0] wtr;
        logic [LIM_W-1:0] rfc;
    } tlim_t;

    function automatic logic [LIM_W-1:0] floor1(logic [3:0] f);
        return (f == 4'd0) ? LIM_W'(1) : LIM_W'(f);
    endfunction

    function automatic logic [LIM_W-1:0] sat_inc(logic [LIM_W-1:0] x);
        return (&x) ? x : x + LIM_W'(1);
    endfunction

    function automatic tlim_t decode_timing(logic [CFG_W-1:0] w);
        tlim_t t;
        t.rcd   = floor1(w[3:0]);
        t.rp    = floor1(w[19:16]);
        t.rrd   = floor1(w[23:20]);
        t.rc_wr = LIM_W'(w[27:24]) + LIM_W'(1);
        t.rc_rd = LIM_W'(w[31:28]) + LIM_W'(1);
        t.wtr   = LIM_W'(w[43:40]);
        t.rfc   = LIM_W'(w[55:52]);
        return t;
    endfunction

endpackage

// File: rtl/dct_bank_track.sv
module dct_bank_track
    import dct_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  tlim_t lim,
    input  logic  act_go,
    input  logic  col_go,
    input  logic  col_wr,
    input  logic  pre_go,
    output logic  open_o,
    output logic  act_ok_o,
    output logic  col_ok_o,
    output logic  rp_ok_o
);

    logic             open_q;
    logic             wrote_q;
    logic [LIM_W-1:0] since_act_q;
    logic [LIM_W-1:0] since_pre_q;
    logic [LIM_W-1:0] rc_lim;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q      <= 1'b0;
            wrote_q     <= 1'b0;
            since_act_q <= '1;
            since_pre_q <= '1;
        end else begin
            since_act_q <= act_go ? LIM_W'(1) : sat_inc(since_act_q);
            since_pre_q <= pre_go ? LIM_W'(1) : sat_inc(since_pre_q);
            if (act_go) begin
                open_q  <= 1'b1;
                wrote_q <= 1'b0;
            end else begin
                if (pre_go)
                    open_q <= 1'b0;
                if (col_go && col_wr)
                    wrote_q <= 1'b1;
            end
        end
    end

    always_comb begin
        rc_lim   = wrote_q ? lim.rc_wr : lim.rc_rd;
        rp_ok_o  = (since_pre_q >= lim.rp);
        act_ok_o = !open_q && rp_ok_o && (since_act_q >= rc_lim);
        col_ok_o = open_q && (since_act_q >= lim.rcd);
        open_o   = open_q;
    end

endmodule

// File: rtl/dct_global_track.sv
module dct_global_track
    import dct_pkg::*;
#(
    parameter int BANK_W = 2
)(
    input  logic              clk,
    input  logic              rst,
    input  tlim_t             lim,
    input  logic              act_go,
    input  logic [BANK_W-1:0] act_bank,
    input  logic              wr_go,
    input  logic              ref_go,
    output logic [BANK_W-1:0] last_bank_o,
    output logic              rrd_ok_o,
    output logic              wtr_ok_o,
    output logic              rfc_ok_o
);

    logic [LIM_W-1:0]  since_act_q;
    logic [LIM_W-1:0]  since_wr_q;
    logic [LIM_W-1:0]  since_ref_q;
    logic [BANK_W-1:0] last_bank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_act_q <= '1;
            since_wr_q  <= '1;
            since_ref_q <= '1;
            last_bank_q <= '0;
        end else begin
            since_act_q <= act_go ? LIM_W'(1) : sat_inc(since_act_q);
            since_wr_q  <= wr_go  ? LIM_W'(1) : sat_inc(since_wr_q);
            since_ref_q <= ref_go ? LIM_W'(1) : sat_inc(since_ref_q);
            if (act_go)
                last_bank_q <= act_bank;
        end
    end

    always_comb begin
        last_bank_o = last_bank_q;
        rrd_ok_o    = (since_act_q >= lim.rrd);
        wtr_ok_o    = (since_wr_q  >= lim.wtr);
        rfc_ok_o    = (since_ref_q >= lim.rfc);
    end

endmodule

// File: rtl/dct_prio_arb.sv
module dct_prio_arb #(
    parameter int N = 4
)(
    input  logic [N-1:0] cand_i,
    output logic [N-1:0] gnt_o
);

    always_comb begin
        gnt_o = '0;
        for (int i = 0; i < N; i++) begin
            if (cand_i[i])
                gnt_o = N'(1) << i;
        end
    end

endmodule

// File: rtl/dram_timing_guard.sv
module dram_timing_guard
    import dct_pkg::*;
#(
    parameter  int NBANK  = 4,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  cfg_i,
    input  logic              ref_req_i,
    input  logic              pre_req_i,
    input  logic [BANK_W-1:0] pre_bank_i,
    input  logic              col_req_i,
    input  logic              col_wr_i,
    input  logic [BANK_W-1:0] col_bank_i,
    input  logic              act_req_i,
    input  logic [BANK_W-1:0] act_bank_i,
    output logic [N_CLS-1:0]  grant_o,
    output logic [N_CLS-1:0]  illegal_o,
    output logic              cmd_valid_o,
    output logic [2:0]        cmd_o,
    output logic [BANK_W-1:0] cmd_bank_o
);

    tlim_t             lim;
    logic [NBANK-1:0]  open_v;
    logic [NBANK-1:0]  act_ok_v;
    logic [NBANK-1:0]  col_ok_v;
    logic [NBANK-1:0]  rp_ok_v;
    logic [BANK_W-1:0] last_bank;
    logic              rrd_ok;
    logic              wtr_ok;
    logic              rfc_ok;
    logic [N_CLS-1:0]  req_v;
    logic [N_CLS-1:0]  legal_v;
    logic [N_CLS-1:0]  ready_v;
    logic [N_CLS-1:0]  cand_v;

    assign lim = decode_timing(cfg_i);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        dct_bank_track u_trk (
            .clk      (clk),
            .rst      (rst),
            .lim      (lim),
            .act_go   (grant_o[CLS_ACT] && (act_bank_i == BANK_W'(b))),
            .col_go   (grant_o[CLS_COL] && (col_bank_i == BANK_W'(b))),
            .col_wr   (col_wr_i),
            .pre_go   (grant_o[CLS_PRE] && (pre_bank_i == BANK_W'(b))),
            .open_o   (open_v[b]),
            .act_ok_o (act_ok_v[b]),
            .col_ok_o (col_ok_v[b]),
            .rp_ok_o  (rp_ok_v[b])
        );
    end

    dct_global_track #(.BANK_W(BANK_W)) u_glb (
        .clk         (clk),
        .rst         (rst),
        .lim         (lim),
        .act_go      (grant_o[CLS_ACT]),
        .act_bank    (act_bank_i),
        .wr_go       (grant_o[CLS_COL] && col_wr_i),
        .ref_go      (grant_o[CLS_REF]),
        .last_bank_o (last_bank),
        .rrd_ok_o    (rrd_ok),
        .wtr_ok_o    (wtr_ok),
        .rfc_ok_o    (rfc_ok)
    );

    always_comb begin
        req_v          = '0;
        req_v[CLS_ACT] = act_req_i;
        req_v[CLS_COL] = col_req_i;
        req_v[CLS_PRE] = pre_req_i;
        req_v[CLS_REF] = ref_req_i;

        legal_v          = '0;
        legal_v[CLS_ACT] = !open_v[act_bank_i];
        legal_v[CLS_COL] = open_v[col_bank_i];
        legal_v[CLS_PRE] = open_v[pre_bank_i];
        legal_v[CLS_REF] = (open_v == '0);

        ready_v          = '0;
        ready_v[CLS_ACT] = act_ok_v[act_bank_i] && rfc_ok &&
                           ((last_bank == act_bank_i) || rrd_ok);
        ready_v[CLS_COL] = col_ok_v[col_bank_i] && (col_wr_i || wtr_ok);
        ready_v[CLS_PRE] = 1'b1;
        ready_v[CLS_REF] = (&rp_ok_v) && rfc_ok;

        cand_v    = req_v & legal_v & ready_v;
        illegal_o = req_v & ~legal_v;
    end

    dct_prio_arb #(.N(N_CLS)) u_arb (
        .cand_i (cand_v),
        .gnt_o  (grant_o)
    );

    always_comb begin
        cmd_valid_o = |grant_o;
        cmd_o       = CMD_NOP;
        cmd_bank_o  = '0;
        if (grant_o[CLS_REF]) begin
            cmd_o = CMD_REF;
        end else if (grant_o[CLS_PRE]) begin
            cmd_o      = CMD_PRE;
            cmd_bank_o = pre_bank_i;
        end else if (grant_o[CLS_COL]) begin
            cmd_o      = col_wr_i ? CMD_WR : CMD_RD;
            cmd_bank_o = col_bank_i;
        end else if (grant_o[CLS_ACT]) begin
            cmd_o      = CMD_ACT;
            cmd_bank_o = act_bank_i;
        end
    end

endmodule

// File: rtl/dram_timing_guard_chk.sv
module dram_timing_guard_chk
    import dct_pkg::*;
#(
    parameter  int NBANK  = 4,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
)(
    input logic              clk,
    input logic              rst,
    input logic [CFG_W-1:0]  cfg_i,
    input logic              ref_req_i,
    input logic              pre_req_i,
    input logic [BANK_W-1:0] pre_bank_i,
    input logic              col_req_i,
    input logic              col_wr_i,
    input logic [BANK_W-1:0] col_bank_i,
    input logic              act_req_i,
    input logic [BANK_W-1:0] act_bank_i,
    input logic [N_CLS-1:0]  grant_o,
    input logic [N_CLS-1:0]  illegal_o,
    input logic              cmd_valid_o,
    input logic [2:0]        cmd_o,
    input logic [BANK_W-1:0] cmd_bank_o
);

    tlim_t lim;
    assign lim = decode_timing(cfg_i);

    logic is_act, is_col, is_wr, is_rd, is_ref;
    assign is_act = cmd_valid_o && (cmd_o == CMD_ACT);
    assign is_wr  = cmd_valid_o && (cmd_o == CMD_WR);
    assign is_rd  = cmd_valid_o && (cmd_o == CMD_RD);
    assign is_col = is_wr || is_rd;
    assign is_ref = cmd_valid_o && (cmd_o == CMD_REF);

    a_r8_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    a_r9_no_illegal_grant: assert property (@(posedge clk) disable iff (rst)
        (grant_o & illegal_o) == '0);

    a_r2_rcd_gap: assert property (@(posedge clk) disable iff (rst)
        is_act |=> !(is_col && (cmd_bank_o == $past(cmd_bank_o)) && (lim.rcd > LIM_W'(1))));

    a_r4_rrd_gap: assert property (@(posedge clk) disable iff (rst)
        is_act |=> !(is_act && (cmd_bank_o != $past(cmd_bank_o)) && (lim.rrd > LIM_W'(1))));

    a_r6_wtr_gap: assert property (@(posedge clk) disable iff (rst)
        is_wr |=> !(is_rd && (lim.wtr > LIM_W'(1))));

    a_r7_rfc_gap: assert property (@(posedge clk) disable iff (rst)
        is_ref |=> !((is_act || is_ref) && (lim.rfc > LIM_W'(1))));

    a_r5_act_same_bank: assert property (@(posedge clk) disable iff (rst)
        is_act |=> !(is_act && (cmd_bank_o == $past(cmd_bank_o))));

endmodule

bind dram_timing_guard dram_timing_guard_chk #(.NBANK(NBANK)) u_chk (.*);

// File: tb/dram_timing_guard_tb.sv
`timescale 1ns/1ps
module dram_timing_guard_tb;

    localparam int NB = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] cfg = 64'h0;
    logic        ref_req = 0, pre_req = 0, col_req = 0, col_wr = 0, act_req = 0;
    logic [1:0]  pre_bank = 0, col_bank = 0, act_bank = 0;
    logic [3:0]  grant_o, illegal_o;
    logic        cmd_valid_o;
    logic [2:0]  cmd_o;
    logic [1:0]  cmd_bank_o;

    always #2 clk = ~clk;

    dram_timing_guard #(.NBANK(NB)) u_dut (
        .clk(clk), .rst(rst), .cfg_i(cfg),
        .ref_req_i(ref_req), .pre_req_i(pre_req), .pre_bank_i(pre_bank),
        .col_req_i(col_req), .col_wr_i(col_wr), .col_bank_i(col_bank),
        .act_req_i(act_req), .act_bank_i(act_bank),
        .grant_o(grant_o), .illegal_o(illegal_o), .cmd_valid_o(cmd_valid_o),
        .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    task automatic check(string tag, string what, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // behavioural reference model
    int cyc;
    bit m_open[NB];
    bit m_wrote[NB];
    int m_act_t[NB];
    int m_pre_t[NB];
    int m_last_bank, m_last_act_t, m_wr_t, m_ref_t;
    logic [3:0] e_gnt, e_ill;
    int e_cmd, e_bank;

    function automatic int fld(int lo);
        return int'(cfg[lo +: 4]);
    endfunction
    function automatic int min1(int v);
        return (v == 0) ? 1 : v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            cyc = 0;
            for (int b = 0; b < NB; b++) begin
                m_open[b] = 0; m_wrote[b] = 0; m_act_t[b] = -1000; m_pre_t[b] = -1000;
            end
            m_last_bank = 0; m_last_act_t = -1000; m_wr_t = -1000; m_ref_t = -1000;
        end else begin
            if (e_gnt[3]) m_ref_t = cyc;
            if (e_gnt[2]) begin m_open[pre_bank] = 0; m_pre_t[pre_bank] = cyc; end
            if (e_gnt[1] && col_wr) begin m_wrote[col_bank] = 1; m_wr_t = cyc; end
            if (e_gnt[0]) begin
                m_open[act_bank] = 1; m_wrote[act_bank] = 0; m_act_t[act_bank] = cyc;
                m_last_bank = act_bank; m_last_act_t = cyc;
            end
            cyc = cyc + 1;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            int ab, cb, pb, rowlim;
            bit any_open, all_rp;
            logic [3:0] cand, req, leg;
            ab = act_bank; cb = col_bank; pb = pre_bank;
            any_open = 0; all_rp = 1;
            for (int b = 0; b < NB; b++) begin
                if (m_open[b]) any_open = 1;
                if (cyc - m_pre_t[b] < min1(fld(16))) all_rp = 0;
            end
            req = {ref_req, pre_req, col_req, act_req};
            leg = {!any_open, m_open[pb], m_open[cb], !m_open[ab]};
            e_ill = req & ~leg;
            rowlim = (m_wrote[ab] ? fld(24) : fld(28)) + 1;
            cand[0] = (cyc - m_pre_t[ab] >= min1(fld(16))) && (cyc - m_act_t[ab] >= rowlim) &&
                      (cyc - m_ref_t >= fld(52)) &&
                      (ab == m_last_bank || cyc - m_last_act_t >= min1(fld(20)));
            cand[1] = (cyc - m_act_t[cb] >= min1(fld(0))) && (col_wr || cyc - m_wr_t >= fld(40));
            cand[2] = 1;
            cand[3] = all_rp && (cyc - m_ref_t >= fld(52));
            cand = cand & req & leg;
            e_gnt = 0; e_cmd = 0; e_bank = 0;
            if (cand[3]) begin e_gnt = 4'b1000; e_cmd = 5; end
            else if (cand[2]) begin e_gnt = 4'b0100; e_cmd = 4; e_bank = pb; end
            else if (cand[1]) begin e_gnt = 4'b0010; e_cmd = col_wr ? 3 : 2; e_bank = cb; end
            else if (cand[0]) begin e_gnt = 4'b0001; e_cmd = 1; e_bank = ab; end
            check("R8", "grant vector", grant_o, e_gnt);
            check("R9", "illegal vector", illegal_o, e_ill);
            check("R11", "command code", cmd_o, e_cmd);
            check("R11", "command bank", cmd_bank_o, e_bank);
            check("R11", "command valid", cmd_valid_o, e_gnt != 0);
        end
    end

    // stimulus helpers (always entered and left at posedge + 1)
    function automatic logic [63:0] mk(int rcd, int rp, int rrd, int rcw, int rcr,
                                       int wtr, int rfc, bit junk);
        logic [63:0] w;
        w = junk ? ~64'h0 : 64'h0;
        w[3:0] = 4'(rcd); w[19:16] = 4'(rp); w[23:20] = 4'(rrd);
        w[27:24] = 4'(rcw); w[31:28] = 4'(rcr); w[43:40] = 4'(wtr); w[55:52] = 4'(rfc);
        return w;
    endfunction

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_reqs();
        ref_req = 0; pre_req = 0; col_req = 0; act_req = 0; col_wr = 0;
    endtask

    // cls: 0 act, 1 col, 2 pre, 3 ref
    task automatic issue(int cls, int bank, bit wr, output int t);
        t = -1;
        clear_reqs();
        case (cls)
            0: begin act_req = 1; act_bank = 2'(bank); end
            1: begin col_req = 1; col_bank = 2'(bank); col_wr = wr; end
            2: begin pre_req = 1; pre_bank = 2'(bank); end
            default: ref_req = 1;
        endcase
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (grant_o[cls]) t = cyc;
            @(posedge clk); #1;
            if (t >= 0) break;
        end
        clear_reqs();
        if (t < 0) check("R8", "request never granted", 0, 1);
    endtask

    task automatic close_all();
        int t;
        for (int b = 0; b < NB; b++)
            if (m_open[b]) issue(2, b, 0, t);
        idle(20);
    endtask

    task automatic gap2(string tag, int c1, int b1, bit w1, int c2, int b2, bit w2, int exp);
        int t1, t2;
        issue(c1, b1, w1, t1);
        issue(c2, b2, w2, t2);
        check(tag, "gap", t2 - t1, exp);
    endtask

    initial begin
        int t1, t2, t3;
        #1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        cfg = mk(1, 1, 1, 0, 0, 0, 0, 0);
        // R1: reset state
        @(negedge clk);
        check("R1", "grant after reset", grant_o, 0);
        check("R1", "cmd_valid after reset", cmd_valid_o, 0);
        @(posedge clk); #1;
        col_req = 1; col_bank = 0; pre_req = 1; pre_bank = 2;
        @(negedge clk);
        check("R1", "column and precharge to closed banks flagged", illegal_o, 4'b0110);
        check("R9", "illegal requests not granted", grant_o, 0);
        @(posedge clk); #1; clear_reqs();

        // R2: activate to column
        cfg = mk(5, 1, 1, 0, 0, 0, 0, 0);
        gap2("R2", 0, 0, 0, 1, 0, 0, 5);
        close_all();
        cfg = mk(0, 1, 1, 0, 0, 0, 0, 0);
        gap2("R2", 0, 1, 0, 1, 1, 1, 1);
        close_all();
        // R10: reserved bits set to ones change nothing
        cfg = mk(5, 1, 1, 0, 0, 0, 0, 1);
        gap2("R10", 0, 2, 0, 1, 2, 0, 5);
        close_all();

        // R3: precharge to activate
        cfg = mk(1, 4, 1, 0, 0, 0, 0, 0);
        issue(0, 1, 0, t1);
        gap2("R3", 2, 1, 0, 0, 1, 0, 4);
        close_all();

        // R4: activate to activate, different bank vs same bank
        cfg = mk(1, 1, 3, 0, 0, 0, 0, 0);
        gap2("R4", 0, 0, 0, 0, 1, 0, 3);
        close_all();
        issue(0, 2, 0, t1); issue(2, 2, 0, t2); issue(0, 2, 0, t3);
        check("R4", "same bank reopen exempt", t3 - t1, 2);
        close_all();

        // R5: row cycle chosen by write history
        cfg = mk(1, 1, 1, 7, 5, 0, 0, 0);
        issue(0, 2, 0, t1); issue(1, 2, 1, t2); issue(2, 2, 0, t2); issue(0, 2, 0, t3);
        check("R5", "row cycle after write", t3 - t1, 8);
        close_all();
        issue(0, 3, 0, t1); issue(1, 3, 0, t2); issue(2, 3, 0, t2); issue(0, 3, 0, t3);
        check("R5", "row cycle read only", t3 - t1, 6);
        close_all();

        // R6: write to read across banks
        cfg = mk(1, 1, 1, 0, 0, 6, 0, 0);
        issue(0, 0, 0, t1); issue(0, 1, 0, t1);
        gap2("R6", 1, 0, 1, 1, 1, 0, 6);
        close_all();

        // R7: refresh recovery and refresh preconditions
        cfg = mk(1, 1, 1, 0, 0, 0, 9, 0);
        gap2("R7", 3, 0, 0, 0, 0, 0, 9);
        close_all();
        gap2("R7", 3, 0, 0, 3, 0, 0, 9);
        idle(20);
        issue(0, 0, 0, t1);
        ref_req = 1;
        @(negedge clk);
        check("R9", "refresh with open bank flagged", illegal_o, 4'b1000);
        check("R7", "refresh with open bank not granted", grant_o, 0);
        @(posedge clk); #1; clear_reqs();
        cfg = mk(1, 4, 1, 0, 0, 0, 0, 0);
        gap2("R7", 2, 0, 0, 3, 0, 0, 4);
        idle(20);

        // R8: priority
        cfg = mk(1, 1, 1, 0, 0, 0, 0, 0);
        issue(0, 0, 0, t1); issue(0, 1, 0, t1); idle(3);
        pre_req = 1; pre_bank = 0; col_req = 1; col_bank = 1; act_req = 1; act_bank = 3;
        @(negedge clk);
        check("R8", "precharge beats column and activate", grant_o, 4'b0100);
        @(posedge clk); #1; pre_req = 0;
        @(negedge clk);
        check("R8", "column beats activate", grant_o, 4'b0010);
        check("R11", "read code", cmd_o, 2);
        @(posedge clk); #1; col_req = 0;
        @(negedge clk);
        check("R8", "activate alone", grant_o, 4'b0001);
        check("R11", "activate bank", cmd_bank_o, 3);
        @(posedge clk); #1; clear_reqs();
        close_all();
        ref_req = 1; act_req = 1; act_bank = 2;
        @(negedge clk);
        check("R8", "refresh beats activate", grant_o, 4'b1000);
        @(posedge clk); #1; clear_reqs();
        idle(20);

        // random phases against the model
        for (int seg = 0; seg < 6; seg++) begin
            cfg = mk($urandom_range(0, 6), $urandom_range(0, 4), $urandom_range(0, 4),
                     $urandom_range(0, 12), $urandom_range(0, 12), $urandom_range(0, 8),
                     $urandom_range(0, 12), 1'($urandom_range(0, 1)));
            for (int k = 0; k < 2000; k++) begin
                ref_req  = ($urandom_range(0, 15) == 0);
                pre_req  = ($urandom_range(0, 3) == 0);
                col_req  = ($urandom_range(0, 1) == 0);
                act_req  = ($urandom_range(0, 1) == 0);
                col_wr   = 1'($urandom_range(0, 1));
                pre_bank = 2'($urandom_range(0, 3));
                col_bank = 2'($urandom_range(0, 3));
                act_bank = 2'($urandom_range(0, 3));
                @(posedge clk); #1;
            end
            clear_reqs();
            idle(20);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule